// File: doc/BRIEF.md
# Memory Pattern Self-Test Engine

This block is a built-in test controller for one byte-wide synchronous static RAM. On a write command it steps through every location in ascending order. It stores a byte derived from the address: either the low address byte counting up from 0x00, or its bitwise inverse counting down from 0xFF. On a separate compare command it reads every location back, in the same order, and checks each byte against the byte the active pattern predicts.

The RAM returns read data one cycle after the address. The compare stage carries the address and the predicted byte through a one-stage pipeline, so a check completes one cycle after its read is issued. A compare pass halts at the first mismatch. It keeps the failing address, the predicted byte and the byte it received. The host selects the pattern with a toggle pulse between passes. Busy, complete and fail are reported as levels, and they hold until the next pass is accepted.

Top module: `mpb_engine`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, mem_en_o and pat_sel_o are all 0. A pat_sel_o value of 0 selects the up-counting pattern and 1 selects the down-counting pattern.
- R2: With pat_sel_o = 0, a write pass writes the byte a[7:0] to each address a. The addresses run 0 to 2^ADDR_W-1, ascending, one per cycle. busy_o is high for exactly 2^ADDR_W cycles, and the pass then ends with done_o = 1 and fail_o = 0.
- R3: With pat_sel_o = 1, a write pass writes the byte 0xFF - a[7:0] (the inverse of the R2 byte) to each address a.
- R4: A pulse on pat_toggle_i while the engine is idle inverts pat_sel_o one cycle later.
- R5: A compare pass reads all addresses in ascending order and checks each byte one cycle after its read. When no byte differs, busy_o is high for 2^ADDR_W+1 cycles and the pass ends with done_o = 1 and fail_o = 0.
- R6: At the first mismatch, at address a, the compare pass stops. It issues no read beyond address a+1 and ends with fail_o = 1 and done_o = 0. err_addr_o holds a, err_exp_o holds the predicted byte and err_got_o holds the byte read.
- R7: done_o, fail_o and the error fields hold while the engine is idle, including across a toggle pulse. An accepted start clears done_o and fail_o in the first busy cycle.
- R8: Start and toggle pulses that arrive while busy_o is 1 are ignored. The running pass keeps its length, pat_sel_o does not change, and no new pass follows.
- R9: When start_wr_i and start_rd_i are both high in the same idle cycle, a write pass runs.
- R10: When a toggle pulse and a start pulse arrive in the same idle cycle, both take effect, and the pass uses the newly selected pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_wr_i | input | 1 | Pulse: begin a write pass |
| start_rd_i | input | 1 | Pulse: begin a compare pass |
| pat_toggle_i | input | 1 | Pulse: swap the active pattern |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write enable (read when 0) |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data, valid one cycle after the read |
| busy_o | output | 1 | A pass is running |
| done_o | output | 1 | Last pass completed without a mismatch |
| fail_o | output | 1 | Last compare pass found a mismatch |
| pat_sel_o | output | 1 | Active pattern: 0 = up-counting, 1 = down-counting |
| err_addr_o | output | ADDR_W | Address of the first mismatch |
| err_exp_o | output | 8 | Predicted byte at that address |
| err_got_o | output | 8 | Byte read at that address |

## Verification
A pattern toggle and a start command can be accepted in the same idle cycle. The engine must apply the toggle before the first write of the new pass. The bench raises both pulses in one cycle and then judges the result in two ways: the scoreboard compares every write of the pass against bytes predicted from the inverted pattern, and the memory image is read afterwards. A second collision, both start pulses together, is provoked in the same way and judged by the pass length and by the write enable the scoreboard sees on each access.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_DRAIN = 2'd3
    } mpb_state_e;

    typedef enum logic {
        PAT_UP   = 1'b0,
        PAT_DOWN = 1'b1
    } mpb_pat_e;

    // byte stored at a location whose low address byte is lo
    function automatic logic [7:0] pattern_byte(input logic [7:0] lo, input mpb_pat_e sel);
        return (sel == PAT_DOWN) ? ~lo : lo;
    endfunction

endpackage

// File: rtl/mpb_addr_ctr.sv
module mpb_addr_ctr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] cnt,
    output logic              last
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign last = (cnt == {ADDR_W{1'b1}});
endmodule

// File: rtl/mpb_cmp_stage.sv
module mpb_cmp_stage #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [7:0]        issue_exp,
    input  logic [7:0]        rdata,
    output logic              vld,
    output logic [ADDR_W-1:0] addr_q,
    output logic [7:0]        exp_q,
    output logic              miss
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld    <= 1'b0;
            addr_q <= '0;
            exp_q  <= '0;
        end else begin
            vld <= issue;
            if (issue) begin
                addr_q <= issue_addr;
                exp_q  <= issue_exp;
            end
        end
    end

    assign miss = vld && (rdata != exp_q);
endmodule

// File: rtl/mpb_engine.sv
module mpb_engine
    import mpb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_wr_i,
    input  logic              start_rd_i,
    input  logic              pat_toggle_i,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic              pat_sel_o,
    output logic [ADDR_W-1:0] err_addr_o,
    output logic [7:0]        err_exp_o,
    output logic [7:0]        err_got_o
);
    localparam int LO_W = (ADDR_W < 8) ? ADDR_W : 8;

    mpb_state_e        state_q;
    mpb_pat_e          pat_q;
    logic              done_q, fail_q;
    logic [ADDR_W-1:0] err_addr_q;
    logic [7:0]        err_exp_q, err_got_q;

    logic              idle, go_wr, go_rd, stepping, issue_rd;
    logic [ADDR_W-1:0] cnt;
    logic              cnt_last;
    logic [7:0]        addr_lo, pat_byte;
    logic              cmp_vld, cmp_miss, miss_hit;
    logic [ADDR_W-1:0] cmp_addr;
    logic [7:0]        cmp_exp;

    assign idle     = (state_q == ST_IDLE);
    assign go_wr    = idle && start_wr_i;
    assign go_rd    = idle && start_rd_i && !start_wr_i;
    assign stepping = (state_q == ST_WRITE) || (state_q == ST_READ);
    assign issue_rd = (state_q == ST_READ);

    generate
        if (ADDR_W >= 8) begin : g_wide
            assign addr_lo = cnt[LO_W-1:0];
        end else begin : g_narrow
            assign addr_lo = {{(8-LO_W){1'b0}}, cnt};
        end
    endgenerate

    assign pat_byte = pattern_byte(addr_lo, pat_q);

    mpb_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (go_wr || go_rd),
        .inc  (stepping),
        .cnt  (cnt),
        .last (cnt_last)
    );

    mpb_cmp_stage #(.ADDR_W(ADDR_W)) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .issue      (issue_rd),
        .issue_addr (cnt),
        .issue_exp  (pat_byte),
        .rdata      (mem_rdata_i),
        .vld        (cmp_vld),
        .addr_q     (cmp_addr),
        .exp_q      (cmp_exp),
        .miss       (cmp_miss)
    );

    assign miss_hit = cmp_vld && cmp_miss &&
                      ((state_q == ST_READ) || (state_q == ST_DRAIN));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            pat_q      <= PAT_UP;
            done_q     <= 1'b0;
            fail_q     <= 1'b0;
            err_addr_q <= '0;
            err_exp_q  <= '0;
            err_got_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (pat_toggle_i) pat_q <= (pat_q == PAT_UP) ? PAT_DOWN : PAT_UP;
                    if (go_wr || go_rd) begin
                        done_q  <= 1'b0;
                        fail_q  <= 1'b0;
                        state_q <= go_wr ? ST_WRITE : ST_READ;
                    end
                end
                ST_WRITE: begin
                    if (cnt_last) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_READ: begin
                    if (miss_hit) begin
                        fail_q     <= 1'b1;
                        err_addr_q <= cmp_addr;
                        err_exp_q  <= cmp_exp;
                        err_got_q  <= mem_rdata_i;
                        state_q    <= ST_IDLE;
                    end else if (cnt_last) begin
                        state_q <= ST_DRAIN;
                    end
                end
                default: begin
                    if (miss_hit) begin
                        fail_q     <= 1'b1;
                        err_addr_q <= cmp_addr;
                        err_exp_q  <= cmp_exp;
                        err_got_q  <= mem_rdata_i;
                    end else begin
                        done_q <= 1'b1;
                    end
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign mem_en_o    = stepping;
    assign mem_we_o    = (state_q == ST_WRITE);
    assign mem_addr_o  = cnt;
    assign mem_wdata_o = pat_byte;
    assign busy_o      = !idle;
    assign done_o      = done_q;
    assign fail_o      = fail_q;
    assign pat_sel_o   = pat_q;
    assign err_addr_o  = err_addr_q;
    assign err_exp_o   = err_exp_q;
    assign err_got_o   = err_got_q;
endmodule

// File: rtl/mpb_engine_chk.sv
module mpb_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start_wr_i,
    input logic              start_rd_i,
    input logic              mem_en_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              fail_o,
    input logic              pat_sel_o,
    input logic [ADDR_W-1:0] err_addr_o
);
    AST_END_HAS_VERDICT: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (done_o ^ fail_o)); // R5

    AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done_o && fail_o)); // R6

    AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (rst)
        mem_en_o |=> (mem_en_o -> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)))); // R2

    AST_PAT_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o -> $stable(pat_sel_o))); // R8

    AST_IDLE_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_wr_i && !start_rd_i) |=> $stable({done_o, fail_o, err_addr_o})); // R7

    AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && (start_wr_i || start_rd_i)) |=> busy_o); // R2

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (!done_o && !fail_o)); // R7
endmodule

bind mpb_engine mpb_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_wr_i (start_wr_i),
    .start_rd_i (start_rd_i),
    .mem_en_o   (mem_en_o),
    .mem_addr_o (mem_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .pat_sel_o  (pat_sel_o),
    .err_addr_o (err_addr_o)
);

// File: tb/mpb_engine_tb.sv
module mpb_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 4;
    localparam int DEPTH      = 1 << AW;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [7:0]    data;
    } acc_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_wr_i = 1'b0, start_rd_i = 1'b0, pat_toggle_i = 1'b0;
    logic mem_en_o, mem_we_o;
    logic [AW-1:0] mem_addr_o, err_addr_o;
    logic [7:0] mem_wdata_o, mem_rdata_i, err_exp_o, err_got_o;
    logic busy_o, done_o, fail_o, pat_sel_o;

    logic [7:0] mem [DEPTH];
    acc_t exp_q[$];
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpb_engine #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst),
        .start_wr_i(start_wr_i), .start_rd_i(start_rd_i), .pat_toggle_i(pat_toggle_i),
        .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .pat_sel_o(pat_sel_o),
        .err_addr_o(err_addr_o), .err_exp_o(err_exp_o), .err_got_o(err_got_o)
    );

    // synchronous RAM model, one cycle read latency
    always @(posedge clk) begin
        if (mem_en_o && mem_we_o)  mem[mem_addr_o] <= mem_wdata_o;
        if (mem_en_o && !mem_we_o) mem_rdata_i <= mem[mem_addr_o];
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] pbyte(input int a, input bit down);
        logic [7:0] lo;
        lo = 8'(a);
        return down ? 8'(8'hFF - lo) : lo;
    endfunction

    // driver side of the scoreboard
    task automatic push_writes(input bit down);
        for (int a = 0; a < DEPTH; a++) exp_q.push_back('{1'b1, AW'(a), pbyte(a, down)});
    endtask

    task automatic push_reads(input int n);
        for (int a = 0; a < n; a++) exp_q.push_back('{1'b0, AW'(a), 8'h00});
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (!rst && mem_en_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 R5 R6 unexpected access", int'(mem_addr_o), -1);
            end else begin
                acc_t e;
                e = exp_q.pop_front();
                chk(mem_we_o == e.we, "R9 access kind", int'(mem_we_o), int'(e.we));
                chk(mem_addr_o == e.addr, "R2 R5 access address", int'(mem_addr_o), int'(e.addr));
                if (e.we)
                    chk(mem_wdata_o == e.data, "R2 R3 R10 write data", int'(mem_wdata_o), int'(e.data));
            end
        end
    end

    task automatic cmd(input bit wr, input bit rd, input bit tg);
        @(negedge clk);
        start_wr_i = wr; start_rd_i = rd; pat_toggle_i = tg;
        @(negedge clk);
        start_wr_i = 0; start_rd_i = 0; pat_toggle_i = 0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy_o) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int cyc;
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'h55;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk(!busy_o && !done_o && !fail_o && !mem_en_o, "R1 reset status", {busy_o, done_o, fail_o, mem_en_o}, 0);
        chk(pat_sel_o == 1'b0, "R1 reset pattern", pat_sel_o, 0);

        // R2 write up pattern
        push_writes(1'b0);
        cmd(1, 0, 0);
        wait_idle(cyc);
        chk(cyc == DEPTH, "R2 write pass length", cyc, DEPTH);
        chk(done_o && !fail_o, "R2 write done", {done_o, fail_o}, 2);
        for (int i = 0; i < DEPTH; i++) chk(mem[i] == pbyte(i, 0), "R2 memory image", mem[i], pbyte(i, 0));

        // R5 clean compare
        push_reads(DEPTH);
        cmd(0, 1, 0);
        wait_idle(cyc);
        chk(cyc == DEPTH + 1, "R5 compare pass length", cyc, DEPTH + 1);
        chk(done_o && !fail_o, "R5 compare done", {done_o, fail_o}, 2);

        // R4 toggle, R7 status survives it
        cmd(0, 0, 1);
        chk(pat_sel_o == 1'b1, "R4 toggle to down pattern", pat_sel_o, 1);
        chk(done_o && !fail_o, "R7 status kept over toggle", {done_o, fail_o}, 2);

        // R6 mismatch at address 0
        push_reads(2);
        cmd(0, 1, 0);
        wait_idle(cyc);
        chk(cyc == 2, "R6 early stop length", cyc, 2);
        chk(fail_o && !done_o, "R6 fail status", {done_o, fail_o}, 1);
        chk(err_addr_o == 0 && err_exp_o == 8'hFF && err_got_o == 8'h00, "R6 capture at 0",
            {err_addr_o, err_exp_o, err_got_o}, {4'h0, 8'hFF, 8'h00});

        // R3 write down pattern and compare
        push_writes(1'b1);
        cmd(1, 0, 0);
        wait_idle(cyc);
        for (int i = 0; i < DEPTH; i++) chk(mem[i] == pbyte(i, 1), "R3 memory image", mem[i], pbyte(i, 1));
        push_reads(DEPTH);
        cmd(0, 1, 0);
        wait_idle(cyc);
        chk(done_o && !fail_o, "R5 compare down pattern", {done_o, fail_o}, 2);

        // R6 injected fault at address 5
        mem[5] = mem[5] ^ 8'h10;
        push_reads(7);
        cmd(0, 1, 0);
        wait_idle(cyc);
        chk(cyc == 7, "R6 stop after next read", cyc, 7);
        chk(fail_o && err_addr_o == 5 && err_exp_o == 8'hFA && err_got_o == 8'hEA, "R6 capture at 5",
            {fail_o, err_addr_o, err_exp_o, err_got_o}, {1'b1, 4'h5, 8'hFA, 8'hEA});
        chk(exp_q.size() == 0, "R6 no access past a+1", exp_q.size(), 0);

        // R7 hold while idle
        repeat (5) @(negedge clk);
        chk(fail_o && !done_o && err_addr_o == 5 && err_got_o == 8'hEA, "R7 error held",
            {fail_o, done_o, err_addr_o, err_got_o}, {1'b1, 1'b0, 4'h5, 8'hEA});

        // R8 commands while busy ignored; R7 start clears fail
        push_writes(1'b1);
        cmd(1, 0, 0);
        chk(!fail_o && !done_o, "R7 start clears status", {done_o, fail_o}, 0);
        cyc = 0;
        while (busy_o) begin
            pat_toggle_i = (cyc == 3);
            start_rd_i   = (cyc == 3);
            cyc++;
            @(negedge clk);
        end
        pat_toggle_i = 0; start_rd_i = 0;
        chk(cyc == DEPTH, "R8 pass length unchanged", cyc, DEPTH);
        chk(pat_sel_o == 1'b1, "R8 pattern unchanged", pat_sel_o, 1);
        repeat (2) @(negedge clk);
        chk(!busy_o && done_o, "R8 no pass follows", {busy_o, done_o}, 1);

        // R9 both starts together
        push_writes(1'b1);
        cmd(1, 1, 0);
        wait_idle(cyc);
        chk(cyc == DEPTH, "R9 write wins length", cyc, DEPTH);

        // R10 toggle with start
        push_writes(1'b0);
        cmd(1, 0, 1);
        wait_idle(cyc);
        chk(pat_sel_o == 1'b0, "R10 toggle applied", pat_sel_o, 0);
        chk(mem[7] == 8'h07, "R10 new pattern written", mem[7], 8'h07);
        push_reads(DEPTH);
        cmd(0, 1, 0);
        wait_idle(cyc);
        chk(done_o && !fail_o, "R5 final compare", {done_o, fail_o}, 2);
        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

        finish_run();
    end
endmodule